// File: doc/BRIEF.md
# LRU Tag Store with Access Counting

This block is the tag side of a set-associative cache. Each request carries an address and is either a lookup or a fill. A lookup compares the request tag against every way of the indexed set at once. It reports whether one of them matches and, if so, which way. A fill writes the request tag into a chosen way of the set. Both hits and fills make the touched way the most recently used one of its set, and fills pick their victim from that ordering. The data array, miss handling and the memory side are not part of the block.

Two saturating counters run beside the tag array and support power estimates:
- The tag-access counter records how many tag entries were read or written.
- The data-access counter records how many data blocks would have been read or written.

A static mode input selects the data-side access style. In parallel mode, every data way is read on every lookup. In sequential mode, the data array is read only after a hit, and then only one block. A clear input zeroes both counters.

Requests use a valid/ready handshake, and one request is accepted per cycle. The response (valid, hit, way) and the counter updates appear on the cycle after acceptance.

Top module: `lruTagStore`

## Requirements
- R1: Every accepted lookup adds WAYS to the tag-access counter, whether it hits or misses.
- R2: With seqMode low (parallel), every accepted lookup adds WAYS to the data-access counter, whether it hits or misses.
- R3: With seqMode high (sequential), an accepted lookup that hits adds exactly 1 to the data-access counter.
- R4: With seqMode high, an accepted lookup that misses leaves the data-access counter unchanged.
- R5: Every accepted fill adds 1 to the tag-access counter and 1 to the data-access counter, in either mode.
- R6: The address is split into fields as follows:
  - The offset is the low log2(BLOCK_BYTES) bits.
  - The set index is the next log2(SETS) bits, where SETS = CACHE_BYTES / (BLOCK_BYTES * WAYS).
  - The tag is the remaining upper bits.

  A lookup hits only when a valid way of the indexed set holds the request tag, whatever the offset. The cycle after acceptance, respValid is 1 and respHit shows the result. respWay gives the matching way on a hit and 0 on a miss.
- R7: A fill reports respHit = 0. respWay gives the way written, chosen in this order:
  - the way that already holds the request tag, if there is one;
  - otherwise, the lowest-numbered invalid way of the set;
  - otherwise, the least recently used way.
- R8: A lookup hit and a fill each make the touched way the most recently used of its set. The other ways keep their relative order. The order in one set is not affected by traffic to other sets.
- R9: Both counters saturate at all ones and never wrap.
- R10: clrCounters zeroes both counters on the next cycle. It takes priority over an increment from a request accepted in the same cycle, but that request still updates the tags and LRU order and still responds.
- R11: During and after reset, both counters are 0, respValid is 0 and every way is invalid. reqReady is 0 while reset is asserted and 1 from the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seqMode | input | 1 | 1 = tags then data (sequential), 0 = tags and data together (parallel) |
| clrCounters | input | 1 | Synchronous clear of both access counters |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqFill | input | 1 | 1 = fill, 0 = lookup |
| reqAddr | input | ADDR_W | Request byte address |
| respValid | output | 1 | Response for the request accepted in the previous cycle |
| respHit | output | 1 | Lookup matched a valid way |
| respWay | output | WAY_W | Matching way (lookup hit) or written way (fill) |
| tagCount | output | CNT_W | Saturating tag-access count |
| dataCount | output | CNT_W | Saturating data-access count |

## Verification
A counter clear and a counted request can land on the same clock edge. The clear must win for the counters, while the request still completes its tag-side work. The bench raises clrCounters together with an accepted lookup to a resident block. It then expects both counters at zero and, in the same response, a hit on the known way. A second case clears during a fill and later confirms through a lookup that the fill took effect. The checker also asserts that clear forces zero whatever was accepted alongside it.

// File: rtl/tagStorePkg.sv
package tagStorePkg;

  // Strobes handed from the control to the datapath for one accepted request.
  typedef struct packed {
    logic doLookup;
    logic doFill;
  } tsStrobe_t;

endpackage

// File: rtl/tagStoreSatCount.sv
module tagStoreSatCount #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W:0] sumWide;

  assign sumWide = {1'b0, count} + (CNT_W+1)'(inc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (sumWide[CNT_W]) begin
      count <= '1;
    end else begin
      count <= sumWide[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/tagStoreCtrl.sv
module tagStoreCtrl
  import tagStorePkg::*;
#(
  parameter int WAYS  = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seqMode,
  input  logic             clrCounters,
  input  logic             reqValid,
  input  logic             reqFill,
  input  logic             hitNow,
  output logic             reqReady,
  output tsStrobe_t        strobe,
  output logic             respValid,
  output logic [CNT_W-1:0] tagCount,
  output logic [CNT_W-1:0] dataCount
);

  localparam int INC_W = $clog2(WAYS + 1);
  localparam logic [INC_W-1:0] WAYS_INC = INC_W'(WAYS);
  localparam logic [INC_W-1:0] ONE_INC  = INC_W'(1);

  logic             readyQ;
  logic             accepted;
  logic [INC_W-1:0] tagInc;
  logic [INC_W-1:0] dataInc;

  assign reqReady = readyQ;
  assign accepted = reqValid && readyQ;

  always_comb begin
    strobe.doLookup = accepted && !reqFill;
    strobe.doFill   = accepted && reqFill;
  end

  // Tag side: all ways compared per lookup, one entry written per fill.
  // Data side: parallel reads every way; sequential reads one way on a hit only.
  always_comb begin
    tagInc  = '0;
    dataInc = '0;
    if (strobe.doLookup) begin
      tagInc = WAYS_INC;
      if (seqMode) begin
        dataInc = hitNow ? ONE_INC : '0;
      end else begin
        dataInc = WAYS_INC;
      end
    end else if (strobe.doFill) begin
      tagInc  = ONE_INC;
      dataInc = ONE_INC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      respValid <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      respValid <= accepted;
    end
  end

  tagStoreSatCount #(.CNT_W(CNT_W), .INC_W(INC_W)) u_tagCnt (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (clrCounters),
    .inc   (tagInc),
    .count (tagCount)
  );

  tagStoreSatCount #(.CNT_W(CNT_W), .INC_W(INC_W)) u_dataCnt (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (clrCounters),
    .inc   (dataInc),
    .count (dataCount)
  );

endmodule

// File: rtl/tagStoreDatapath.sv
module tagStoreDatapath
  import tagStorePkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int SETS        = 64,
  parameter int WAYS        = 4,
  parameter int WAY_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              hitNow,
  output logic              respHit,
  output logic [WAY_W-1:0]  respWay
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [WAY_W-1:0] LRU_RANK = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAY_W-1:0] rankMem  [SETS][WAYS];

  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] invWay;
  logic             anyInvalid;
  logic [WAY_W-1:0] lruWay;
  logic [WAY_W-1:0] fillWay;
  logic [WAY_W-1:0] touchWay;
  logic [WAY_W-1:0] oldRank;
  logic             touch;

  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validMem[reqIdx][w] && (tagMem[reqIdx][w] == reqTag);
  end

  assign hitNow     = |hitVec;
  assign anyInvalid = ~&validMem[reqIdx];

  // Lowest-numbered matching way, lowest invalid way, and the rank-max way.
  always_comb begin
    hitWay = '0;
    invWay = '0;
    lruWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (!validMem[reqIdx][w]) invWay = WAY_W'(w);
      if (rankMem[reqIdx][w] == LRU_RANK) lruWay = WAY_W'(w);
    end
  end

  always_comb begin
    if (hitNow)          fillWay = hitWay;
    else if (anyInvalid) fillWay = invWay;
    else                 fillWay = lruWay;
  end

  assign touch    = strobe.doFill || (strobe.doLookup && hitNow);
  assign touchWay = strobe.doFill ? fillWay : hitWay;
  assign oldRank  = rankMem[reqIdx][touchWay];

  // Validity and LRU ranks: reset to empty sets with ranks equal to way number.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          rankMem[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.doFill) begin
        validMem[reqIdx][fillWay] <= 1'b1;
      end
      if (touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay) begin
            rankMem[reqIdx][w] <= '0;
          end else if (rankMem[reqIdx][w] < oldRank) begin
            rankMem[reqIdx][w] <= rankMem[reqIdx][w] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doFill) begin
      tagMem[reqIdx][fillWay] <= reqTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respHit <= 1'b0;
      respWay <= '0;
    end else if (strobe.doLookup || strobe.doFill) begin
      respHit <= strobe.doLookup && hitNow;
      if (strobe.doFill)  respWay <= fillWay;
      else if (hitNow)    respWay <= hitWay;
      else                respWay <= '0;
    end
  end

endmodule

// File: rtl/lruTagStore.sv
module lruTagStore
  import tagStorePkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int BLOCK_BYTES = 64,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32,
  localparam int SETS       = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqMode,
  input  logic              clrCounters,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqFill,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic              respHit,
  output logic [WAY_W-1:0]  respWay,
  output logic [CNT_W-1:0]  tagCount,
  output logic [CNT_W-1:0]  dataCount
);

  tsStrobe_t strobe;
  logic      hitNow;

  tagStoreCtrl #(.WAYS(WAYS), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .seqMode     (seqMode),
    .clrCounters (clrCounters),
    .reqValid    (reqValid),
    .reqFill     (reqFill),
    .hitNow      (hitNow),
    .reqReady    (reqReady),
    .strobe      (strobe),
    .respValid   (respValid),
    .tagCount    (tagCount),
    .dataCount   (dataCount)
  );

  tagStoreDatapath #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .SETS        (SETS),
    .WAYS        (WAYS),
    .WAY_W       (WAY_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .hitNow  (hitNow),
    .respHit (respHit),
    .respWay (respWay)
  );

endmodule

// File: rtl/lruTagStoreChecker.sv
module lruTagStoreChecker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 32,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              seqMode,
  input logic              clrCounters,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqFill,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              respValid,
  input logic              respHit,
  input logic [WAY_W-1:0]  respWay,
  input logic [CNT_W-1:0]  tagCount,
  input logic [CNT_W-1:0]  dataCount
);

  localparam logic [CNT_W:0] MAXV   = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0] WAYS_W = (CNT_W+1)'(WAYS);

  logic           accepted;
  logic [CNT_W:0] tagW;
  logic [CNT_W:0] dataW;

  assign accepted = reqValid && reqReady;
  assign tagW     = {1'b0, tagCount};
  assign dataW    = {1'b0, dataCount};

  AST_TAG_PER_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqFill && !clrCounters && tagW + WAYS_W <= MAXV)
    |=> tagW == $past(tagW) + WAYS_W); // R1

  AST_DATA_PARALLEL: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqFill && !seqMode && !clrCounters && dataW + WAYS_W <= MAXV)
    |=> dataW == $past(dataW) + WAYS_W); // R2

  AST_DATA_SEQ_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqFill && seqMode && !clrCounters && dataW < MAXV)
    |=> (!respHit || dataW == $past(dataW) + 1'b1)); // R3

  AST_DATA_SEQ_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqFill && seqMode && !clrCounters)
    |=> (respHit || dataW == $past(dataW))); // R4

  AST_FILL_ONE_EACH: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqFill && !clrCounters && tagW < MAXV && dataW < MAXV)
    |=> (tagW == $past(tagW) + 1'b1 && dataW == $past(dataW) + 1'b1)); // R5

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> respValid); // R6

  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> !respValid); // R6

  AST_FILL_NOT_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqFill) |=> !respHit); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !clrCounters |=> (tagW >= $past(tagW) && dataW >= $past(dataW))); // R9

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrCounters |=> (tagCount == '0 && dataCount == '0)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!accepted && !clrCounters) |=> ($stable(tagCount) && $stable(dataCount))); // R10

  always_comb begin
    if (!rstN) begin
      AST_RESET_STATE: assert (tagCount == '0 && dataCount == '0 && !respValid && !reqReady); // R11
    end
  end

endmodule

bind lruTagStore lruTagStoreChecker #(
  .ADDR_W (ADDR_W),
  .WAYS   (WAYS),
  .CNT_W  (CNT_W),
  .WAY_W  (WAY_W)
) u_chk (.*);

// File: tb/lruTagStore_tb.sv
module lruTagStore_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 16;
  localparam int CACHE_BYTES = 256;
  localparam int BLOCK_BYTES = 16;
  localparam int WAYS        = 4;
  localparam int CNT_W       = 8;
  localparam int MAXC        = (1 << CNT_W) - 1;
  localparam int NVEC        = 16;

  // 4 sets: offset = addr[3:0], index = addr[5:4], tag = addr[15:6].
  typedef struct packed {
    logic        fill;
    logic        seq;
    logic [15:0] addr;
    logic        hit;
    logic [1:0]  way;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 16'h0040, 1'b0, 2'd0},  // miss on empty set
    '{1'b1, 1'b0, 16'h0040, 1'b0, 2'd0},  // lowest invalid way
    '{1'b1, 1'b1, 16'h0080, 1'b0, 2'd1},
    '{1'b1, 1'b0, 16'h00C0, 1'b0, 2'd2},
    '{1'b1, 1'b0, 16'h0100, 1'b0, 2'd3},  // set 0 full
    '{1'b0, 1'b1, 16'h0045, 1'b1, 2'd0},  // seq hit, other offset
    '{1'b0, 1'b1, 16'h0140, 1'b0, 2'd0},  // seq miss
    '{1'b1, 1'b0, 16'h0140, 1'b0, 2'd1},  // LRU victim way 1
    '{1'b0, 1'b0, 16'h0080, 1'b0, 2'd0},  // evicted tag misses
    '{1'b0, 1'b0, 16'h00C8, 1'b1, 2'd2},  // parallel hit
    '{1'b1, 1'b1, 16'h0180, 1'b0, 2'd3},  // LRU victim way 3
    '{1'b1, 1'b0, 16'h0050, 1'b0, 2'd0},  // other set independent
    '{1'b0, 1'b1, 16'h0100, 1'b0, 2'd0},  // evicted
    '{1'b1, 1'b0, 16'h0045, 1'b0, 2'd0},  // resident tag reuses way
    '{1'b0, 1'b1, 16'h0050, 1'b1, 2'd0},
    '{1'b0, 1'b1, 16'h0180, 1'b1, 2'd3}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              seqMode = 1'b0;
  logic              clrCounters = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqFill = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              respValid;
  logic              respHit;
  logic [1:0]        respWay;
  logic [CNT_W-1:0]  tagCount;
  logic [CNT_W-1:0]  dataCount;

  int checks = 0;
  int errors = 0;
  int expTag = 0;
  int expData = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lruTagStore #(
    .ADDR_W      (ADDR_W),
    .CACHE_BYTES (CACHE_BYTES),
    .BLOCK_BYTES (BLOCK_BYTES),
    .WAYS        (WAYS),
    .CNT_W       (CNT_W)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .seqMode     (seqMode),
    .clrCounters (clrCounters),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .reqFill     (reqFill),
    .reqAddr     (reqAddr),
    .respValid   (respValid),
    .respHit     (respHit),
    .respWay     (respWay),
    .tagCount    (tagCount),
    .dataCount   (dataCount)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int satAdd(input int v, input int inc);
    return (v + inc > MAXC) ? MAXC : v + inc;
  endfunction

  // Drive one request at a falling edge; it is accepted at the next rising
  // edge and its results are sampled at the falling edge after that.
  task automatic doReq(input logic fill, input logic seq, input logic [15:0] addr, input logic clr);
    @(negedge clk);
    reqValid    = 1'b1;
    reqFill     = fill;
    seqMode     = seq;
    reqAddr     = addr;
    clrCounters = clr;
    @(posedge clk);
    @(negedge clk);
    reqValid    = 1'b0;
    clrCounters = 1'b0;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "tagCount in reset", int'(tagCount), 0);
    chk("R11", "dataCount in reset", int'(dataCount), 0);
    chk("R11", "respValid in reset", int'(respValid), 0);
    chk("R11", "reqReady in reset", int'(reqReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "reqReady after reset", int'(reqReady), 1);

    // Vector walk: R1..R8 via the reference counter model
    for (int i = 0; i < NVEC; i++) begin
      doReq(VECS[i].fill, VECS[i].seq, VECS[i].addr, 1'b0);
      if (VECS[i].fill) begin
        expTag  = satAdd(expTag, 1);                                   // R5
        expData = satAdd(expData, 1);
      end else begin
        expTag  = satAdd(expTag, WAYS);                                // R1
        if (VECS[i].seq) expData = satAdd(expData, VECS[i].hit ? 1 : 0); // R3 R4
        else             expData = satAdd(expData, WAYS);              // R2
      end
      chk("R6", $sformatf("vec%0d respValid", i), int'(respValid), 1);
      chk(VECS[i].fill ? "R7" : "R6", $sformatf("vec%0d respHit", i), int'(respHit), int'(VECS[i].hit));
      chk(VECS[i].fill ? "R7" : "R8", $sformatf("vec%0d respWay", i), int'(respWay), int'(VECS[i].way));
      chk("R1", $sformatf("vec%0d tagCount", i), int'(tagCount), expTag);
      chk(VECS[i].seq ? "R3" : "R2", $sformatf("vec%0d dataCount", i), int'(dataCount), expData);
    end

    // R6: response lasts one cycle
    @(negedge clk);
    chk("R6", "respValid idle", int'(respValid), 0);

    // R10: clear together with a hitting lookup
    doReq(1'b0, 1'b0, 16'h0045, 1'b1);
    chk("R10", "tagCount cleared over lookup", int'(tagCount), 0);
    chk("R10", "dataCount cleared over lookup", int'(dataCount), 0);
    chk("R10", "hit still reported", int'(respHit), 1);
    chk("R10", "way still reported", int'(respWay), 0);

    // R10: clear together with a fill (set 2, empty) - fill must still land
    doReq(1'b1, 1'b0, 16'h0260, 1'b1);
    chk("R10", "tagCount cleared over fill", int'(tagCount), 0);
    chk("R10", "fill way under clear", int'(respWay), 0);
    doReq(1'b0, 1'b1, 16'h0264, 1'b0);
    chk("R10", "fill under clear resident", int'(respHit), 1);
    chk("R3", "seq hit after clear", int'(dataCount), 1);
    chk("R1", "tag after clear", int'(tagCount), WAYS);

    // R9: saturation, parallel lookups add 4 each
    doReq(1'b0, 1'b0, 16'h0040, 1'b1);
    for (int k = 0; k < 63; k++) doReq(1'b0, 1'b0, 16'h0040, 1'b0);
    chk("R9", "tagCount before saturation", int'(tagCount), 252);
    chk("R2", "dataCount before saturation", int'(dataCount), 252);
    doReq(1'b0, 1'b0, 16'h0040, 1'b0);
    chk("R9", "tagCount saturated", int'(tagCount), MAXC);
    chk("R9", "dataCount saturated", int'(dataCount), MAXC);
    doReq(1'b1, 1'b0, 16'h0040, 1'b0);
    chk("R9", "tagCount stays saturated", int'(tagCount), MAXC);
    chk("R9", "dataCount stays saturated", int'(dataCount), MAXC);
    chk("R7", "refill of resident block", int'(respWay), 0);

    // R4: sequential misses leave data untouched even from zero
    doReq(1'b0, 1'b1, 16'h0F00, 1'b1);
    doReq(1'b0, 1'b1, 16'h0F00, 1'b0);
    chk("R4", "seq miss data unchanged", int'(dataCount), 0);
    chk("R1", "tag counted on seq miss", int'(tagCount), WAYS);

    finishRun();
  end

endmodule